// File: doc/BRIEF.md
# Interrupt Steering Aggregator

This block gathers a wide vector of level-high interrupt requests, organised as `GROUPS` banks of 32 lines, and reduces them to a single interrupt line for a parent controller. Software reaches it through a small 32-bit register port: one plain address, a write strobe, write data and registered read data. Each line can be enabled or blocked per bit. Each line can also be forced pending from software. A live status view shows what is pending now, and a per-bank summary word tells the handler which status words need a look.

The register layout is computed from `GROUPS`. A control word sits at byte 0. Three banks of `GROUPS` words follow it, holding masks, force bits and status. After those come a word that silences the output and a summary word. Per-bank words can be listed in ascending or descending bank order, set by the `REVERSED` parameter. Software written for either word order therefore finds line 0 where it expects it.

Top module: `irq_steer_agg`

## Requirements
- R1: After reset, the control, silence, mask and force registers all read 0, `irq_out` is 0 and `rd_data` is 0.
- R2: The control register is at byte 0x0. Only bit 0 is stored, and reads return it in bit 0 with zeros elsewhere. `irq_out` can be 1 only while this bit is 1.
- R3: Mask word n is at 0x4 + 4n. It reads back the last value written to it. Mask bit b = 1 lets line b of that word through, and 0 blocks it.
- R4: Force word n is at 0x4 + 4n + 4·GROUPS. It reads back the last value written. A 1 in it makes the matching line pending, subject to its mask, until software writes a 0 to that bit.
- R5: Status word n is at 0x4 + 4n + 8·GROUPS. It reads (input bits | force word n) & mask word n, following the input levels with no latching. Writes to it have no effect.
- R6: With `REVERSED`=0, word index n covers input lines 32n..32n+31. With `REVERSED`=1, it covers the lines of bank GROUPS−1−n, so lines 0..31 sit in word GROUPS−1. In both modes, line k uses bit k mod 32 of its word.
- R7: The silence register is at 0x4 + 12·GROUPS. Only bit 0 is stored and read back. While it is 1, `irq_out` is 0.
- R8: The summary register is at 0x8 + 12·GROUPS. Its bit n is the OR of status word n, and its upper bits are 0. It is read-only.
- R9: `irq_out` equals control bit 0 AND NOT silence bit 0 AND (any status bit set), sampled at the previous clock edge.
- R10: Reads of unmapped or non-word-aligned addresses return 0. Writes to them change no register.
- R11: `rd_data` shows the register addressed at a clock edge from that edge onward, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for the address of the previous edge |
| irq_in | input | GROUPS*32 | Level-high interrupt request lines |
| irq_out | output | 1 | Combined interrupt output, registered |

## Verification
A register write takes effect at the edge that samples it. Read data and `irq_out` both need one more edge. Status and summary reads capture the input levels present at the edge that samples the address. The bench therefore changes inputs and bus signals on the falling edge and spends one full cycle on every write. It also lets a read address cross one rising edge and compares `rd_data` and `irq_out` at the following falling edge. That same edge also gives `irq_out` its first value after the write. Two instances with opposite word orders share all stimulus, so a single bench model checks both the forward and the reversed mapping.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int LINES_PER_WORD = 32;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_CTRL  = 3'd1,
    SEL_MASK  = 3'd2,
    SEL_FORCE = 3'd3,
    SEL_STAT  = 3'd4,
    SEL_SILNC = 3'd5,
    SEL_SUMM  = 3'd6
  } sel_kind_e;
endpackage

// File: rtl/irq_steer_decode.sv
module irq_steer_decode
  import irq_steer_pkg::*;
#(
  parameter int GROUPS = 2,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  localparam int MASK_BASE  = 1;
  localparam int FORCE_BASE = 1 + GROUPS;
  localparam int STAT_BASE  = 1 + 2 * GROUPS;
  localparam int SILNC_WORD = 1 + 3 * GROUPS;
  localparam int SUMM_WORD  = 2 + 3 * GROUPS;

  always_comb begin
    int w;
    w    = int'(addr[ADDR_W-1:2]);
    kind = SEL_NONE;
    idx  = '0;
    if (addr[1:0] == 2'b00) begin
      if (w == 0) begin
        kind = SEL_CTRL;
      end else if (w >= MASK_BASE && w < FORCE_BASE) begin
        kind = SEL_MASK;
        idx  = IDX_W'(w - MASK_BASE);
      end else if (w >= FORCE_BASE && w < STAT_BASE) begin
        kind = SEL_FORCE;
        idx  = IDX_W'(w - FORCE_BASE);
      end else if (w >= STAT_BASE && w < SILNC_WORD) begin
        kind = SEL_STAT;
        idx  = IDX_W'(w - STAT_BASE);
      end else if (w == SILNC_WORD) begin
        kind = SEL_SILNC;
      end else if (w == SUMM_WORD) begin
        kind = SEL_SUMM;
      end
    end
  end
endmodule

// File: rtl/irq_steer_bank.sv
module irq_steer_bank
  import irq_steer_pkg::*;
#(
  parameter int GROUPS = 2,
  parameter int IDX_W  = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  sel_kind_e                     kind,
  input  logic [IDX_W-1:0]              idx,
  input  logic [31:0]                   wr_data,
  output logic [GROUPS-1:0][31:0]       mask_q,
  output logic [GROUPS-1:0][31:0]       force_q,
  output logic                          ctrl_en,
  output logic                          silence
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en <= 1'b0;
      silence <= 1'b0;
    end else if (wr_en) begin
      if (kind == SEL_CTRL)  ctrl_en <= wr_data[0];
      if (kind == SEL_SILNC) silence <= wr_data[0];
    end
  end

  for (genvar i = 0; i < GROUPS; i++) begin : g_word
    logic hit_mask, hit_force;
    assign hit_mask  = wr_en && (kind == SEL_MASK)  && (idx == IDX_W'(i));
    assign hit_force = wr_en && (kind == SEL_FORCE) && (idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[i]  <= '0;
        force_q[i] <= '0;
      end else begin
        if (hit_mask)  mask_q[i]  <= wr_data;
        if (hit_force) force_q[i] <= wr_data;
      end
    end

    // R3: a mask word only changes when its own address is written
    assert_mask_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && kind == SEL_MASK && idx == IDX_W'(i)) |=> $stable(mask_q[i]));

    // R4: a force word only changes when its own address is written
    assert_force_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && kind == SEL_FORCE && idx == IDX_W'(i)) |=> $stable(force_q[i]));
  end
endmodule

// File: rtl/irq_steer_combine.sv
module irq_steer_combine
  import irq_steer_pkg::*;
#(
  parameter int GROUPS   = 2,
  parameter bit REVERSED = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [GROUPS*32-1:0]          irq_in,
  input  logic [GROUPS-1:0][31:0]       mask_q,
  input  logic [GROUPS-1:0][31:0]       force_q,
  input  logic                          ctrl_en,
  input  logic                          silence,
  output logic [GROUPS-1:0][31:0]       status,
  output logic [GROUPS-1:0]             summary,
  output logic                          irq_out
);
  for (genvar i = 0; i < GROUPS; i++) begin : g_stat
    localparam int BANK = REVERSED ? (GROUPS - 1 - i) : i;
    assign status[i]  = (irq_in[BANK*LINES_PER_WORD +: LINES_PER_WORD] | force_q[i]) & mask_q[i];
    assign summary[i] = |status[i];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= ctrl_en && !silence && (|summary);
  end

  // R2: output stays low whenever the channel enable was clear
  assert_out_needs_enable_R2: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> !irq_out);

  // R7: output stays low while silenced
  assert_out_silenced_R7: assert property (@(posedge clk) disable iff (rst)
    silence |=> !irq_out);

  // R9: no pending line means no output on the next cycle
  assert_out_needs_pending_R9: assert property (@(posedge clk) disable iff (rst)
    (status == '0) |=> !irq_out);
endmodule

// File: rtl/irq_steer_agg.sv
module irq_steer_agg
  import irq_steer_pkg::*;
#(
  parameter int GROUPS   = 2,
  parameter bit REVERSED = 1'b0,
  parameter int ADDR_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  input  logic [31:0]          wr_data,
  output logic [31:0]          rd_data,
  input  logic [GROUPS*32-1:0] irq_in,
  output logic                 irq_out
);
  localparam int IDX_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  sel_kind_e                kind;
  logic [IDX_W-1:0]         idx;
  logic [GROUPS-1:0][31:0]  mask_q, force_q, status;
  logic [GROUPS-1:0]        summary;
  logic                     ctrl_en, silence;
  logic [31:0]              rd_next;

  irq_steer_decode #(.GROUPS(GROUPS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_decode (
    .addr (addr),
    .kind (kind),
    .idx  (idx)
  );

  irq_steer_bank #(.GROUPS(GROUPS), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .kind    (kind),
    .idx     (idx),
    .wr_data (wr_data),
    .mask_q  (mask_q),
    .force_q (force_q),
    .ctrl_en (ctrl_en),
    .silence (silence)
  );

  irq_steer_combine #(.GROUPS(GROUPS), .REVERSED(REVERSED)) u_combine (
    .clk     (clk),
    .rst     (rst),
    .irq_in  (irq_in),
    .mask_q  (mask_q),
    .force_q (force_q),
    .ctrl_en (ctrl_en),
    .silence (silence),
    .status  (status),
    .summary (summary),
    .irq_out (irq_out)
  );

  always_comb begin
    rd_next = '0;
    case (kind)
      SEL_CTRL:  rd_next[0] = ctrl_en;
      SEL_MASK:  rd_next = mask_q[idx];
      SEL_FORCE: rd_next = force_q[idx];
      SEL_STAT:  rd_next = status[idx];
      SEL_SILNC: rd_next[0] = silence;
      SEL_SUMM:  rd_next[GROUPS-1:0] = summary;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R10: an unmapped address always reads back as zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (kind == SEL_NONE) |=> (rd_data == 32'd0));

  // R8: summary is nonzero exactly when some status bit is pending
  assert_summary_tracks_R8: assert property (@(posedge clk) disable iff (rst)
    ((summary != '0) == (status != '0)));

  // R2: control and silence reads expose only bit 0
  assert_ctrl_narrow_R2: assert property (@(posedge clk) disable iff (rst)
    (kind == SEL_CTRL || kind == SEL_SILNC) |=> (rd_data[31:1] == 31'd0));
endmodule

// File: tb/irq_steer_agg_bench.sv
module irq_steer_agg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int G  = 2;
  localparam int AW = 8;
  localparam int A_MASK  = 4;
  localparam int A_FORCE = 4 + 4 * G;
  localparam int A_STAT  = 4 + 8 * G;
  localparam int A_SILNC = 4 + 12 * G;
  localparam int A_SUMM  = 8 + 12 * G;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0]   addr = '0;
  logic            wr_en = 1'b0;
  logic [31:0]     wr_data = '0;
  logic [G*32-1:0] irq_in = '0;
  logic [31:0]     rd_f, rd_r;
  logic            out_f, out_r;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] m_mask [G];
  logic [31:0] m_force[G];
  logic        m_en, m_sil;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_steer_agg #(.GROUPS(G), .REVERSED(1'b0), .ADDR_W(AW)) u_irq_steer_agg (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_f), .irq_in(irq_in), .irq_out(out_f));

  irq_steer_agg #(.GROUPS(G), .REVERSED(1'b1), .ADDR_W(AW)) u_irq_steer_agg_rev (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_r), .irq_in(irq_in), .irq_out(out_r));

  function automatic logic [31:0] exp_stat(bit rev, int i);
    int b = rev ? (G - 1 - i) : i;
    return (irq_in[b*32 +: 32] | m_force[i]) & m_mask[i];
  endfunction

  function automatic logic [31:0] exp_summ(bit rev);
    logic [31:0] s = '0;
    for (int i = 0; i < G; i++) s[i] = |exp_stat(rev, i);
    return s;
  endfunction

  function automatic logic exp_out(bit rev);
    return m_en && !m_sil && (exp_summ(rev) != 0);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 0) m_en = d[0];
    else if (a == A_SILNC) m_sil = d[0];
    else if (a >= A_MASK && a < A_FORCE && a % 4 == 0) m_mask[(a - A_MASK)/4] = d;
    else if (a >= A_FORCE && a < A_STAT && a % 4 == 0) m_force[(a - A_FORCE)/4] = d;
  endtask

  // address crosses one rising edge; sampled at the following falling edge
  task automatic rd(int a);
    addr = AW'(a); wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_all(string req);
    rd(0);       chk({req, " R2 ctrl"}, rd_f, {31'd0, m_en});
    rd(A_SILNC); chk({req, " R7 silence"}, rd_f, {31'd0, m_sil});
    for (int i = 0; i < G; i++) begin
      rd(A_MASK + 4*i);  chk({req, " R3 mask"}, rd_f, m_mask[i]);
                         chk({req, " R3 mask rev"}, rd_r, m_mask[i]);
      rd(A_FORCE + 4*i); chk({req, " R4 force"}, rd_f, m_force[i]);
      rd(A_STAT + 4*i);  chk({req, " R5 stat"}, rd_f, exp_stat(1'b0, i));
                         chk({req, " R6 stat rev"}, rd_r, exp_stat(1'b1, i));
    end
    rd(A_SUMM);
    chk({req, " R8 summary"}, rd_f, exp_summ(1'b0));
    chk({req, " R8 summary rev"}, rd_r, exp_summ(1'b1));
    chk({req, " R9 out"}, {31'd0, out_f}, {31'd0, exp_out(1'b0)});
    chk({req, " R9 out rev"}, {31'd0, out_r}, {31'd0, exp_out(1'b1)});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < G; i++) begin m_mask[i] = '0; m_force[i] = '0; end
    m_en = 1'b0; m_sil = 1'b0;
    irq_in = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state with all inputs high
    chk("R1 rd_data", rd_f, 32'd0);
    chk("R1 irq_out", {31'd0, out_f}, 32'd0);
    check_all("R1");

    // R2/R3/R9: one line through, enable gates the output
    irq_in = '0; irq_in[5] = 1'b1;
    wr(A_MASK, 32'h0000_0020);
    rd(A_SUMM); chk("R2 out off while disabled", {31'd0, out_f}, 32'd0);
    wr(0, 32'hFFFF_FFFF);
    rd(0); chk("R2 ctrl bit0 only", rd_f, 32'd1);
    chk("R9 out on", {31'd0, out_f}, 32'd1);
    // R6: line 5 lives in word G-1 in reversed mode, masked off there
    chk("R6 rev out off", {31'd0, out_r}, 32'd0);
    check_all("R6");

    // R11: output one cycle after input drops
    @(negedge clk); irq_in[5] = 1'b0;
    @(negedge clk); chk("R9 out follows level", {31'd0, out_f}, 32'd0);

    // R4: force holds line pending until cleared
    wr(A_FORCE, 32'h0000_0020);
    check_all("R4 forced");
    wr(A_FORCE, 32'h0);
    check_all("R4 cleared");

    // R7: silence blocks output
    irq_in[5] = 1'b1;
    wr(A_SILNC, 32'h3);
    check_all("R7 silenced");
    wr(A_SILNC, 32'h0);
    check_all("R7 released");

    // R5: writes to status and summary ignored
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_SUMM, 32'hFFFF_FFFF);
    check_all("R5 ro");

    // R10: unmapped and unaligned accesses
    wr(A_SUMM + 4, 32'hFFFF_FFFF);
    wr(A_MASK + 1, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd(A_SUMM + 4); chk("R10 unmapped read", rd_f, 32'd0);
    rd(A_MASK + 1); chk("R10 unaligned read", rd_f, 32'd0);
    check_all("R10");

    // random mix
    for (int it = 0; it < 150; it++) begin
      int sel;
      irq_in = {$urandom, $urandom};
      sel = $urandom_range(0, 9);
      case (sel)
        0:       wr(0, $urandom);
        1:       wr(A_SILNC, {31'd0, 1'($urandom_range(0, 3) == 0)});
        2, 3, 4: wr(A_MASK + 4*$urandom_range(0, G-1), $urandom & $urandom);
        5, 6:    wr(A_FORCE + 4*$urandom_range(0, G-1), $urandom & $urandom & $urandom);
        default: wr($urandom_range(0, 255), $urandom);
      endcase
      check_all("RND");
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule